// File: doc/BRIEF.md
# External Edge-Triggered Interrupt Port

This unit samples up to seven external interrupt pins, numbered 1 to 7. Position 0 exists in every register but has no function. Each pin has its own trigger setting, chosen from four options:

- active-low level,
- rising edge,
- falling edge,
- either edge.

The unit keeps a direction bit, an enable bit and an event flag for each pin, and drives one request line per pin towards an interrupt controller. Software reaches the state through a small register bus. That bus has a 16-bit trigger-setting register, three byte-wide registers (direction, enable and flag) and a read-only view of the synchronised pin levels.

Every pin passes through a two-stage synchroniser. An edge is found by comparing the newest synchronised sample with the one before it. An edge in an edge-triggered mode sets a flag, and the flag stays set until software writes a 1 to it. In level mode there is no latch: the flag bit and the request simply follow the synchronised pin while it is low.

A build-time parameter selects one of two request maps. The full map gives seven request outputs for pins 1 to 7. The reduced map wires only pins 1, 4 and 7, to three consecutive request outputs, and makes every other pin inert.

Top module: `ext_irq_port`

## Requirements
- R1: Position 0 is inert. Bit 0 of the direction, enable, flag and pin registers, and bits 1:0 of the trigger-setting register, always read 0. Position 0 never raises a request.
- R2: After reset, the trigger-setting, direction, enable and flag registers read 0, and every request output is 0.
- R3: The trigger setting of pin n is held in bits 2n+1:2n of the trigger-setting register. The codes are 00 level, 01 rising edge, 10 falling edge and 11 either edge. An edge of the kind not selected sets no flag.
- R4: In level mode, a pin's flag bit reads 1 exactly while its synchronised level is 0, and it reads 0 again once the pin returns high. Nothing is latched.
- R5: An edge flag stays set until software writes a 1 to that bit of the flag register. Writing 0 to a flag bit leaves it unchanged.
- R6: Suppose a qualifying edge is detected on the same clock edge as a write-1 clear of that flag. The flag then stays set.
- R7: A request output is the AND of the pin's enable bit and its flag. A disabled pin still shows its flag on read but raises no request.
- R8: A pin whose direction bit is 1 (output) sets no edge flag and shows no level flag. Its direction bit also drives pin_oe_o.
- R9: After a pin changes between clock edges, an edge flag becomes visible after the third rising clock edge. A level flag becomes visible after the second.
- R10: Full map (REDUCED=0): irq_o[k] serves pin k+1. Reduced map (REDUCED=1): irq_o[0], irq_o[1] and irq_o[2] serve pins 1, 4 and 7. In the reduced map, all register bits of the other pins read 0 and ignore writes.
- R11: Address 4 returns the synchronised pin levels, masked to the live pins.
- R12: Register addresses are 0 trigger setting (16 bits), 1 direction, 2 enable, 3 flag and 4 pin levels. The byte registers use bus_wdata[7:0] and read back zero-extended. Any other address reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 8 | External pin levels; bit 0 is unused |
| pin_oe_o | output | 8 | Per-pin output enable, taken from the direction register |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| irq_o | output | 7 (3 when REDUCED=1) | Per-pin interrupt requests |

## Verification
The bench samples flags one edge before and one edge after the expected moment:

- An extra or missing synchroniser stage moves the flag off that moment, so the check fails.
- A design that treats a falling edge as a trigger in rising mode latches a flag that should stay clear.

It times a write-1 clear to land on the same clock edge as a fresh rising edge. A design that lets the clear win loses that event and reads 0.

It also makes these checks:

- It writes 0 to a set flag. A design that treats the write as a plain store clears the flag.
- It holds a pin low in level mode and then releases it. A latching design keeps the request high after release.
- It drives both map variants from the same stimulus. A wrong reduced map sends pin 4 to the wrong output, or shows state for pins that do not exist.

// File: rtl/xint_pkg.sv
package xint_pkg;

  localparam int unsigned POS_W  = 8;
  localparam int unsigned MODE_W = 2 * POS_W;
  localparam int unsigned BUS_W  = MODE_W;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [1:0] {
    TRIG_LEVEL = 2'b00,
    TRIG_RISE  = 2'b01,
    TRIG_FALL  = 2'b10,
    TRIG_BOTH  = 2'b11
  } trig_e;

  typedef enum logic [ADDR_W-1:0] {
    RA_MODE = 3'd0,
    RA_DIR  = 3'd1,
    RA_EN   = 3'd2,
    RA_FLAG = 3'd3,
    RA_PIN  = 3'd4
  } reg_addr_e;

  // number of request outputs for a map variant
  function automatic int unsigned irq_count(input bit reduced);
    return reduced ? 3 : 7;
  endfunction

  // pin position served by request output k
  function automatic int unsigned out_line(input bit reduced, input int unsigned k);
    return reduced ? (1 + 3 * k) : (1 + k);
  endfunction

  // positions that carry a working pin
  function automatic logic [POS_W-1:0] live_mask(input bit reduced);
    logic [POS_W-1:0] m;
    m = '0;
    for (int unsigned k = 0; k < irq_count(reduced); k++) begin
      m[out_line(reduced, k)] = 1'b1;
    end
    return m;
  endfunction

  // widen a per-pin mask to the two-bit trigger fields
  function automatic logic [MODE_W-1:0] mode_mask(input logic [POS_W-1:0] live);
    logic [MODE_W-1:0] m;
    m = '0;
    for (int unsigned p = 0; p < POS_W; p++) begin
      m[2*p +: 2] = {2{live[p]}};
    end
    return m;
  endfunction

  // does a sample pair form an edge of the selected kind
  function automatic logic edge_fires(input trig_e m, input logic cur, input logic prev);
    case (m)
      TRIG_RISE: return cur & ~prev;
      TRIG_FALL: return ~cur & prev;
      TRIG_BOTH: return cur ^ prev;
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/xint_sync.sv
module xint_sync #(
  parameter int unsigned         W      = 8,
  parameter int unsigned         STAGES = 2,
  parameter logic [W-1:0]        IDLE   = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] q_prev_o
);

  // chain[0] is the first capture flop; chain[STAGES] is the delayed copy
  logic [STAGES:0][W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= {(STAGES+1){IDLE}};
    end else begin
      chain <= {chain[STAGES-1:0], d_i};
    end
  end

  assign q_o      = chain[STAGES-1];
  assign q_prev_o = chain[STAGES];

endmodule

// File: rtl/xint_detect.sv
module xint_detect
  import xint_pkg::*;
#(
  parameter bit REDUCED = 1'b0
) (
  input  logic [POS_W-1:0]  cur_i,
  input  logic [POS_W-1:0]  prev_i,
  input  logic [POS_W-1:0]  dir_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic [POS_W-1:0]  edge_hit_o,
  output logic [POS_W-1:0]  lvl_sel_o,
  output logic [POS_W-1:0]  lvl_on_o
);

  localparam logic [POS_W-1:0] LIVE = live_mask(REDUCED);

  for (genvar p = 0; p < POS_W; p++) begin : g_pos
    if (LIVE[p]) begin : g_live
      trig_e mode;
      assign mode          = trig_e'(mode_i[2*p +: 2]);
      assign edge_hit_o[p] = !dir_i[p] && edge_fires(mode, cur_i[p], prev_i[p]);
      assign lvl_sel_o[p]  = (mode == TRIG_LEVEL);
      assign lvl_on_o[p]   = (mode == TRIG_LEVEL) && !dir_i[p] && !cur_i[p];
    end else begin : g_dead
      logic unused_bits;
      assign unused_bits   = ^{cur_i[p], prev_i[p], dir_i[p], mode_i[2*p +: 2]};
      assign edge_hit_o[p] = 1'b0;
      assign lvl_sel_o[p]  = 1'b0;
      assign lvl_on_o[p]   = 1'b0;
    end
  end

endmodule

// File: rtl/xint_regs.sv
module xint_regs
  import xint_pkg::*;
#(
  parameter bit REDUCED = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [POS_W-1:0]  edge_hit_i,
  input  logic [POS_W-1:0]  lvl_sel_i,
  input  logic [POS_W-1:0]  lvl_on_i,
  input  logic [POS_W-1:0]  pin_lvl_i,
  output logic [MODE_W-1:0] mode_o,
  output logic [POS_W-1:0]  dir_o,
  output logic [POS_W-1:0]  en_o,
  output logic [POS_W-1:0]  flag_q_o,
  output logic [POS_W-1:0]  flag_eff_o
);

  localparam logic [POS_W-1:0]  LIVE  = live_mask(REDUCED);
  localparam logic [MODE_W-1:0] MMASK = mode_mask(LIVE);
  localparam int unsigned       PADW  = BUS_W - POS_W;

  logic [MODE_W-1:0] mode_q;
  logic [POS_W-1:0]  dir_q, en_q, flag_q;
  logic              wr_mode, wr_dir, wr_en, wr_flag;
  logic [POS_W-1:0]  wbyte, clr_bits, flag_next;

  assign wbyte   = bus_wdata[POS_W-1:0];
  assign wr_mode = bus_we && (bus_addr == RA_MODE);
  assign wr_dir  = bus_we && (bus_addr == RA_DIR);
  assign wr_en   = bus_we && (bus_addr == RA_EN);
  assign wr_flag = bus_we && (bus_addr == RA_FLAG);

  assign clr_bits = wr_flag ? (wbyte & LIVE) : '0;

  // a fresh edge outranks a clear; level-mode lines hold nothing
  assign flag_next = ((flag_q & ~clr_bits) | edge_hit_i) & ~lvl_sel_i & LIVE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      dir_q  <= '0;
      en_q   <= '0;
      flag_q <= '0;
    end else begin
      if (wr_mode) mode_q <= bus_wdata & MMASK;
      if (wr_dir)  dir_q  <= wbyte & LIVE;
      if (wr_en)   en_q   <= wbyte & LIVE;
      flag_q <= flag_next;
    end
  end

  assign flag_eff_o = ((lvl_sel_i & lvl_on_i) | (~lvl_sel_i & flag_q)) & LIVE;

  always_comb begin
    case (bus_addr)
      RA_MODE: bus_rdata = mode_q;
      RA_DIR:  bus_rdata = {{PADW{1'b0}}, dir_q};
      RA_EN:   bus_rdata = {{PADW{1'b0}}, en_q};
      RA_FLAG: bus_rdata = {{PADW{1'b0}}, flag_eff_o};
      RA_PIN:  bus_rdata = {{PADW{1'b0}}, pin_lvl_i & LIVE};
      default: bus_rdata = '0;
    endcase
  end

  assign mode_o   = mode_q;
  assign dir_o    = dir_q;
  assign en_o     = en_q;
  assign flag_q_o = flag_q;

endmodule

// File: rtl/xint_route.sv
module xint_route
  import xint_pkg::*;
#(
  parameter bit           REDUCED = 1'b0,
  localparam int unsigned NIRQ    = irq_count(REDUCED)
) (
  input  logic [POS_W-1:0] en_i,
  input  logic [POS_W-1:0] flag_i,
  output logic [NIRQ-1:0]  irq_o
);

  localparam logic [POS_W-1:0] LIVE = live_mask(REDUCED);

  for (genvar k = 0; k < NIRQ; k++) begin : g_out
    localparam int unsigned LINE = out_line(REDUCED, k);
    assign irq_o[k] = en_i[LINE] & flag_i[LINE];
  end

  logic unused_bits;
  assign unused_bits = ^((en_i | flag_i) & ~LIVE);

endmodule

// File: rtl/ext_irq_port.sv
module ext_irq_port
  import xint_pkg::*;
#(
  parameter bit           REDUCED     = 1'b0,
  parameter int unsigned  SYNC_STAGES = 2,
  localparam int unsigned NIRQ        = irq_count(REDUCED)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [POS_W-1:0]  pin_i,
  output logic [POS_W-1:0]  pin_oe_o,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic [NIRQ-1:0]   irq_o
);

  // named internal events, visible to the bound checker
  logic [POS_W-1:0]  pin_lvl, pin_prev;
  logic [POS_W-1:0]  edge_hit, lvl_sel, lvl_on;
  logic [MODE_W-1:0] mode_q;
  logic [POS_W-1:0]  dir_q, en_q, flag_q, flag_eff;

  xint_sync #(
    .W      (POS_W),
    .STAGES (SYNC_STAGES),
    .IDLE   ({POS_W{1'b1}})
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .d_i      (pin_i),
    .q_o      (pin_lvl),
    .q_prev_o (pin_prev)
  );

  xint_detect #(.REDUCED(REDUCED)) u_detect (
    .cur_i      (pin_lvl),
    .prev_i     (pin_prev),
    .dir_i      (dir_q),
    .mode_i     (mode_q),
    .edge_hit_o (edge_hit),
    .lvl_sel_o  (lvl_sel),
    .lvl_on_o   (lvl_on)
  );

  xint_regs #(.REDUCED(REDUCED)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .edge_hit_i (edge_hit),
    .lvl_sel_i  (lvl_sel),
    .lvl_on_i   (lvl_on),
    .pin_lvl_i  (pin_lvl),
    .mode_o     (mode_q),
    .dir_o      (dir_q),
    .en_o       (en_q),
    .flag_q_o   (flag_q),
    .flag_eff_o (flag_eff)
  );

  xint_route #(.REDUCED(REDUCED)) u_route (
    .en_i   (en_q),
    .flag_i (flag_eff),
    .irq_o  (irq_o)
  );

  assign pin_oe_o = dir_q;

endmodule

// File: rtl/ext_irq_port_chk.sv
module ext_irq_port_chk
  import xint_pkg::*;
#(
  parameter bit           REDUCED = 1'b0,
  localparam int unsigned NIRQ    = irq_count(REDUCED)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BUS_W-1:0]  bus_wdata,
  input logic [NIRQ-1:0]   irq_o,
  input logic [POS_W-1:0]  pin_lvl,
  input logic [POS_W-1:0]  edge_hit,
  input logic [POS_W-1:0]  lvl_sel,
  input logic [POS_W-1:0]  dir_q,
  input logic [POS_W-1:0]  en_q,
  input logic [POS_W-1:0]  flag_q,
  input logic [POS_W-1:0]  flag_eff
);

  logic wr_flag, wr_mode;
  assign wr_flag = bus_we && (bus_addr == RA_FLAG);
  assign wr_mode = bus_we && (bus_addr == RA_MODE);

  logic unused_chk;
  assign unused_chk = ^{bus_wdata[BUS_W-1:POS_W], bus_wdata[0], flag_q[0],
                        pin_lvl[0], lvl_sel[0]};

  // R1: position 0 never holds state or fires
  a_r1_pos0_inert: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_eff[0] && !en_q[0] && !dir_q[0] && !edge_hit[0]);

  for (genvar i = 1; i < POS_W; i++) begin : g_line
    // R6: a detected edge is always latched, even against a clear
    a_r6_edge_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_hit[i] && !wr_mode) |=> flag_q[i]);

    // R5: writing 1 clears the flag when no edge competes
    a_r5_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_flag && bus_wdata[i] && !edge_hit[i]) |=> !flag_q[i]);

    // R5: without a clear the flag holds
    a_r5_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[i] && !(wr_flag && bus_wdata[i]) && !wr_mode) |=> flag_q[i]);

    // R4: level mode mirrors the inverted synchronised pin
    a_r4_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_sel[i] && !dir_q[i]) |-> (flag_eff[i] == !pin_lvl[i]));

    // R8: output-direction lines produce no events
    a_r8_output_silent: assert property (@(posedge clk) disable iff (!rst_n)
      dir_q[i] |-> (!edge_hit[i] && !(lvl_sel[i] && flag_eff[i])));
  end

  for (genvar k = 0; k < NIRQ; k++) begin : g_req
    localparam int unsigned LINE = out_line(REDUCED, k);
    // R7: a request needs both enable and flag of its mapped pin (R10)
    a_r7_req_gated: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o[k] |-> (en_q[LINE] && flag_eff[LINE]));
  end

endmodule

bind ext_irq_port ext_irq_port_chk #(.REDUCED(REDUCED)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .irq_o     (irq_o),
  .pin_lvl   (pin_lvl),
  .edge_hit  (edge_hit),
  .lvl_sel   (lvl_sel),
  .dir_q     (dir_q),
  .en_q      (en_q),
  .flag_q    (flag_q),
  .flag_eff  (flag_eff)
);

// File: tb/ext_irq_port_tb.sv
module ext_irq_port_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pins = 8'hFF;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] rd_f, rd_r;
  logic [7:0]  oe_f, oe_r;
  logic [6:0]  irq_f;
  logic [2:0]  irq_r;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  ext_irq_port #(.REDUCED(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .pin_i(pins), .pin_oe_o(oe_f),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(rd_f), .irq_o(irq_f));

  ext_irq_port #(.REDUCED(1'b1)) u_dut_r (
    .clk(clk), .rst_n(rst_n), .pin_i(pins), .pin_oe_o(oe_r),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(rd_r), .irq_o(irq_r));

  // kinds: 0 full rdata, 1 full irq, 2 reduced rdata, 3 reduced irq, 4 full oe
  typedef struct {
    int          kind;
    logic [15:0] exp;
    string       req;
  } item_t;

  item_t sb[$];

  // monitor: pops expected items and compares with the outputs
  initial begin
    item_t       it;
    logic [15:0] act;
    forever begin
      wait (sb.size() != 0);
      it = sb.pop_front();
      case (it.kind)
        0:       act = rd_f;
        1:       act = {9'b0, irq_f};
        2:       act = rd_r;
        3:       act = {13'b0, irq_r};
        default: act = {8'b0, oe_f};
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic chk_reg(input logic [2:0] a, input logic [15:0] ef,
                         input logic [15:0] er, input string req);
    bus_addr = a;
    #1;
    sb.push_back('{0, ef, req});
    sb.push_back('{2, er, req});
    wait (sb.size() == 0);
  endtask

  task automatic chk_irq(input logic [6:0] ef, input logic [2:0] er, input string req);
    #1;
    sb.push_back('{1, {9'b0, ef}, req});
    sb.push_back('{3, {13'b0, er}, req});
    wait (sb.size() == 0);
  endtask

  task automatic chk_oe(input logic [7:0] ef, input string req);
    #1;
    sb.push_back('{4, {8'b0, ef}, req});
    wait (sb.size() == 0);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    bus_we    = 1'b1;
    bus_addr  = a;
    bus_wdata = d;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  localparam logic [2:0] A_MODE = 3'd0, A_DIR = 3'd1, A_EN = 3'd2,
                         A_FLAG = 3'd3, A_PIN = 3'd4;

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(3);

    // R2 reset state
    chk_reg(A_MODE, 16'h0, 16'h0, "R2 mode");
    chk_reg(A_DIR,  16'h0, 16'h0, "R2 dir");
    chk_reg(A_EN,   16'h0, 16'h0, "R2 en");
    chk_reg(A_FLAG, 16'h0, 16'h0, "R2 flag");
    chk_irq(7'h0, 3'h0, "R2 irq");
    chk_reg(3'd5, 16'h0, 16'h0, "R12 unused addr");
    chk_reg(A_PIN, 16'h00FE, 16'h0092, "R11 idle pins");

    // R1 / R10 direction masking, R8 output enable
    wr(A_DIR, 16'h00FF);
    chk_reg(A_DIR, 16'h00FE, 16'h0092, "R1 R10 dir mask");
    chk_oe(8'hFE, "R8 oe follows dir");
    wr(A_DIR, 16'h0000);

    // level mode, R4 / R9
    wr(A_EN, 16'h00FF);
    chk_reg(A_EN, 16'h00FE, 16'h0092, "R1 en mask");
    pins[3] = 1'b0;
    wait_n(1);
    chk_reg(A_FLAG, 16'h0, 16'h0, "R9 level not yet");
    wait_n(1);
    chk_reg(A_FLAG, 16'h0008, 16'h0, "R4 R9 level low");
    chk_irq(7'h04, 3'h0, "R4 level irq");
    pins[3] = 1'b1;
    wait_n(2);
    chk_reg(A_FLAG, 16'h0, 16'h0, "R4 level released");
    chk_irq(7'h00, 3'h0, "R4 level irq released");
    pins[1] = 1'b0;
    wait_n(2);
    chk_reg(A_FLAG, 16'h0002, 16'h0002, "R4 pin1 level");
    chk_irq(7'h01, 3'h1, "R10 pin1 map");
    pins[1] = 1'b1;
    wait_n(2);

    // R7 enable gating
    wr(A_EN, 16'h0000);
    pins[3] = 1'b0;
    wait_n(2);
    chk_reg(A_FLAG, 16'h0008, 16'h0, "R7 flag visible");
    chk_irq(7'h0, 3'h0, "R7 disabled");
    pins[3] = 1'b1;
    wait_n(2);
    wr(A_EN, 16'h00FF);

    // rising edge on pin 1, R3 / R9 / R5
    wr(A_MODE, 16'h0004);
    chk_reg(A_MODE, 16'h0004, 16'h0004, "R3 mode readback");
    pins[1] = 1'b0;
    wait_n(3);
    chk_reg(A_FLAG, 16'h0, 16'h0, "R3 fall ignored in rise");
    chk_irq(7'h0, 3'h0, "R3 no irq");
    pins[1] = 1'b1;
    wait_n(2);
    chk_reg(A_FLAG, 16'h0, 16'h0, "R9 edge not yet");
    wait_n(1);
    chk_reg(A_FLAG, 16'h0002, 16'h0002, "R3 R9 rise flag");
    chk_irq(7'h01, 3'h1, "R3 rise irq");
    pins[1] = 1'b0;
    wait_n(3);
    chk_reg(A_FLAG, 16'h0002, 16'h0002, "R5 latched");
    wr(A_FLAG, 16'h0000);
    chk_reg(A_FLAG, 16'h0002, 16'h0002, "R5 write 0 no effect");
    wr(A_FLAG, 16'h0002);
    chk_reg(A_FLAG, 16'h0, 16'h0, "R5 w1c");
    chk_irq(7'h0, 3'h0, "R5 irq cleared");

    // falling edge on pin 4
    wr(A_MODE, 16'h0204);
    pins[4] = 1'b0;
    wait_n(3);
    chk_reg(A_FLAG, 16'h0010, 16'h0010, "R3 fall flag");
    chk_irq(7'h08, 3'h2, "R10 pin4 map");
    wr(A_FLAG, 16'h0010);
    pins[4] = 1'b1;
    wait_n(3);
    chk_reg(A_FLAG, 16'h0, 16'h0, "R3 rise ignored in fall");

    // both edges on pin 7
    wr(A_MODE, 16'hC204);
    pins[7] = 1'b0;
    wait_n(3);
    chk_reg(A_FLAG, 16'h0080, 16'h0080, "R3 both fall");
    wr(A_FLAG, 16'h0080);
    pins[7] = 1'b1;
    wait_n(3);
    chk_reg(A_FLAG, 16'h0080, 16'h0080, "R3 both rise");
    chk_irq(7'h40, 3'h4, "R10 pin7 map");
    wr(A_FLAG, 16'h0080);

    // R8 output direction blocks events
    wr(A_DIR, 16'h0002);
    pins[1] = 1'b1;
    wait_n(3);
    chk_reg(A_FLAG, 16'h0, 16'h0, "R8 output no flag");
    chk_irq(7'h0, 3'h0, "R8 output no irq");
    pins[1] = 1'b0;
    wait_n(3);
    wr(A_DIR, 16'h0000);

    // R6 edge and clear on the same clock edge
    pins[1] = 1'b1;
    wait_n(2);
    wr(A_FLAG, 16'h0002);
    chk_reg(A_FLAG, 16'h0002, 16'h0002, "R6 set wins");
    wr(A_FLAG, 16'h0002);

    // R1 / R10 trigger field masking
    wr(A_MODE, 16'hFFFF);
    chk_reg(A_MODE, 16'hFFFC, 16'hC30C, "R1 R10 mode mask");
    wr(A_MODE, 16'h0000);

    // R11 pin levels, R4 multi-pin level pattern
    pins = 8'hA5;
    wait_n(2);
    chk_reg(A_PIN, 16'h00A4, 16'h0080, "R11 pin levels");
    chk_reg(A_FLAG, 16'h005A, 16'h0012, "R4 level pattern");
    chk_irq(7'h2D, 3'h3, "R10 level pattern irq");

    // R12 writes to an unused address are ignored
    wr(3'd6, 16'hFFFF);
    chk_reg(A_EN, 16'h00FE, 16'h0092, "R12 stray write");
    chk_reg(3'd5, 16'h0, 16'h0, "R12 stray read");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule